// File: doc/BRIEF.md
# Transfer Byte Counter with End-of-Transfer Detection

This block keeps track of how many bytes have moved in a host-controller buffer transfer and decides when that transfer is over. Software uses a command/data register port. It programs a 16-bit transfer length and a small configuration word. The configuration word picks the target buffer (isochronous list or acknowledged list) and the direction. It also chooses whether the end of the transfer comes from an internal byte counter or only from an external end-of-transfer pin.

Setting the enable bit of the configuration word starts a transfer. While the transfer runs, the block requests data words with `dreq`, and the data mover acknowledges each word with `dack`. When the transfer finishes, a one-cycle `eot` pulse is produced and `dreq` drops at the same moment. The finish also sets a sticky all-EOT interrupt bit and a buffer-status flag that records which buffer was filled or drained.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset the stored length, byte count, configuration, interrupt bits and buffer-status bits all read as 0, and `dreq` and `eot` are low.
- R2: Each register access is one cycle. Read data appears on `acc_rdata` in the following cycle. Code A2h writes the length and 22h reads it. Code A1h writes the configuration and 21h reads it. The configuration fields are: bit 0 direction (1 means writing into the buffer), bit 1 buffer (1 means acknowledged list), bit 2 counter select, and bit 4 enable. Reading 21h returns bit 4 as 1 while a transfer is running. Code 23h reads the byte count.
- R3: A length write is checked against the buffer selected at the time of the write, with a limit of 1000h for the acknowledged list and 800h for the isochronous list. A value above the limit is stored as the limit and sets overflow bit 3 of the interrupt register (read 24h). A value at or below the limit is stored unchanged and does not set that bit.
- R4: A configuration write with bit 4 set, made while no transfer is running, clears the byte count. It raises `dreq` in the next cycle only if the stored length is non-zero. With a zero length nothing starts.
- R5: While `dreq` is high, every cycle with `dack` high adds 2 to the byte count. With the counter selected and exactly one byte remaining, it adds 1 instead.
- R6: With counter select set, the cycle after the strobe that makes the count reach the length shows `eot` high for exactly one cycle and `dreq` low.
- R7: With counter select clear, reaching or passing the length does not end the transfer. Only the external pin does.
- R8: An `ext_eot` pulse during a running transfer ends it at once, in either mode and whatever the count. It produces `eot` and drops `dreq`. An `ext_eot` pulse with no transfer running has no effect.
- R9: Every end of transfer sets all-EOT bit 2 of the interrupt register. Bits 2 and 3 stay set until a write to code A4h has a 1 in that position. A 0 leaves the bit as it is.
- R10: At the end of a transfer one buffer-status bit (read 2Ch) is set. Bit 0 means isochronous full and bit 1 means acknowledged full; these follow a write-direction transfer. Bit 2 means isochronous done and bit 3 means acknowledged done; these follow a read-direction transfer. Writing 1s to code ACh clears them.
- R11: `dack` while `dreq` is low leaves the byte count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe |
| acc_code | input | 8 | Command code of the access |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid the cycle after a read code |
| dack | input | 1 | Data word accepted by the data mover |
| ext_eot | input | 1 | External end-of-transfer pulse |
| dreq | output | 1 | Data request, high while a transfer runs |
| eot | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A wrong count shows up directly on `dreq`. A counter that runs ahead drops the request early and gives too few strobes. A counter that runs behind keeps the request high past the expected number of strobes. Either error is visible within the length of one transfer and is caught by comparing the number of strobes with ceil(length/2). An error in clamping, interrupt or buffer-status state is seen on the very next read of the matching code. A stuck running flag shows up as `dreq` staying high, or as bit 4 of the configuration read staying set, one cycle after the expected end.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [7:0] CMD_CFG_RD = 8'h21;
  localparam logic [7:0] CMD_CFG_WR = 8'hA1;
  localparam logic [7:0] CMD_LEN_RD = 8'h22;
  localparam logic [7:0] CMD_LEN_WR = 8'hA2;
  localparam logic [7:0] CMD_CNT_RD = 8'h23;
  localparam logic [7:0] CMD_INT_RD = 8'h24;
  localparam logic [7:0] CMD_INT_WR = 8'hA4;
  localparam logic [7:0] CMD_BST_RD = 8'h2C;
  localparam logic [7:0] CMD_BST_WR = 8'hAC;

  localparam int INT_ALLEOT = 2;
  localparam int INT_OVF    = 3;
  localparam int CFG_EN_BIT = 4;

  typedef struct packed {
    logic cnt_sel;  // bit 2
    logic buf_atl;  // bit 1
    logic dir_wr;   // bit 0
  } cfg_t;

  function automatic cnt_t pick_limit(input logic buf_atl, input cnt_t itl_max, input cnt_t atl_max);
    return buf_atl ? atl_max : itl_max;
  endfunction

  function automatic cnt_t clamp_len(input cnt_t v, input cnt_t lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic cnt_t step_size(input cnt_t cnt, input cnt_t len, input logic use_cnt);
    if (use_cnt && (len - cnt == cnt_t'(1))) return cnt_t'(1);
    return cnt_t'(2);
  endfunction

  function automatic logic reaches(input cnt_t cnt, input cnt_t stp, input cnt_t len);
    logic [CNT_W:0] sum;
    sum = {1'b0, cnt} + {1'b0, stp};
    return sum >= {1'b0, len};
  endfunction
endpackage

// File: rtl/dxc_regs.sv
module dxc_regs
  import dxc_pkg::*;
#(
  parameter cnt_t ITL_MAX = 16'h0800,
  parameter cnt_t ATL_MAX = 16'h1000
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic [7:0] acc_code,
  input  cnt_t       acc_wdata,
  input  logic       active,
  input  cnt_t       count,
  input  logic [3:0] intr,
  input  logic [3:0] bstat,
  output cfg_t       cfg_q,
  output cnt_t       len_q,
  output cnt_t       acc_rdata,
  output logic       ovf_evt,
  output logic       start_evt,
  output logic [3:0] int_clr,
  output logic [3:0] bst_clr
);
  logic wr_len, wr_cfg;
  cnt_t lim, rd_mux;

  assign wr_len    = acc_valid && (acc_code == CMD_LEN_WR);
  assign wr_cfg    = acc_valid && (acc_code == CMD_CFG_WR);
  assign lim       = pick_limit(cfg_q.buf_atl, ITL_MAX, ATL_MAX);
  assign ovf_evt   = wr_len && (acc_wdata > lim);
  assign start_evt = wr_cfg && acc_wdata[CFG_EN_BIT] && !active;
  assign int_clr   = (acc_valid && acc_code == CMD_INT_WR) ? acc_wdata[3:0] : 4'b0;
  assign bst_clr   = (acc_valid && acc_code == CMD_BST_WR) ? acc_wdata[3:0] : 4'b0;

  always_comb begin
    rd_mux = '0;
    unique case (acc_code)
      CMD_CFG_RD: rd_mux = cnt_t'({active, 1'b0, cfg_q});
      CMD_LEN_RD: rd_mux = len_q;
      CMD_CNT_RD: rd_mux = count;
      CMD_INT_RD: rd_mux = cnt_t'(intr);
      CMD_BST_RD: rd_mux = cnt_t'(bstat);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      len_q     <= '0;
      acc_rdata <= '0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_t'(acc_wdata[2:0]);
      if (wr_len) len_q <= clamp_len(acc_wdata, lim);
      if (acc_valid) acc_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dxc_counter.sv
module dxc_counter
  import dxc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic dack,
  input  logic ext_eot,
  input  cnt_t len_q,
  input  cfg_t cfg_q,
  output logic active,
  output cnt_t count_q,
  output logic eot_evt,
  output logic eot_q
);
  cnt_t stp;
  logic strobe, int_end;

  assign stp     = step_size(count_q, len_q, cfg_q.cnt_sel);
  assign strobe  = active && dack;
  assign int_end = strobe && cfg_q.cnt_sel && reaches(count_q, stp, len_q);
  assign eot_evt = active && (ext_eot || int_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      count_q <= '0;
      eot_q   <= 1'b0;
    end else begin
      eot_q <= eot_evt;
      if (start_evt) begin
        count_q <= '0;
        active  <= (len_q != '0);
      end else begin
        if (strobe)  count_q <= count_q + stp;
        if (eot_evt) active  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dxc_status.sv
module dxc_status
  import dxc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eot_evt,
  input  logic       ovf_evt,
  input  cfg_t       cfg_q,
  input  logic [3:0] int_clr,
  input  logic [3:0] bst_clr,
  output logic [3:0] intr_q,
  output logic [3:0] bstat_q
);
  logic [3:0] int_set, bst_set;
  logic [1:0] bsel;

  assign bsel = {!cfg_q.dir_wr, cfg_q.buf_atl};

  always_comb begin
    int_set = '0;
    int_set[INT_ALLEOT] = eot_evt;
    int_set[INT_OVF]    = ovf_evt;
    bst_set = '0;
    if (eot_evt) bst_set[bsel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intr_q  <= '0;
      bstat_q <= '0;
    end else begin
      intr_q  <= (intr_q & ~int_clr) | int_set;
      bstat_q <= (bstat_q & ~bst_clr) | bst_set;
    end
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dxc_pkg::*;
#(
  parameter cnt_t ITL_MAX = 16'h0800,
  parameter cnt_t ATL_MAX = 16'h1000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [7:0]  acc_code,
  input  logic [15:0] acc_wdata,
  output logic [15:0] acc_rdata,
  input  logic        dack,
  input  logic        ext_eot,
  output logic        dreq,
  output logic        eot
);
  cfg_t       cfg_q;
  cnt_t       len_q, count_q;
  logic       active, ovf_evt, start_evt, eot_evt, eot_q;
  logic [3:0] int_clr, bst_clr, intr_q, bstat_q;

  dxc_regs #(.ITL_MAX(ITL_MAX), .ATL_MAX(ATL_MAX)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_code(acc_code),
    .acc_wdata(acc_wdata), .active(active), .count(count_q), .intr(intr_q),
    .bstat(bstat_q), .cfg_q(cfg_q), .len_q(len_q), .acc_rdata(acc_rdata),
    .ovf_evt(ovf_evt), .start_evt(start_evt), .int_clr(int_clr), .bst_clr(bst_clr)
  );

  dxc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .dack(dack),
    .ext_eot(ext_eot), .len_q(len_q), .cfg_q(cfg_q), .active(active),
    .count_q(count_q), .eot_evt(eot_evt), .eot_q(eot_q)
  );

  dxc_status u_stat (
    .clk(clk), .rst_n(rst_n), .eot_evt(eot_evt), .ovf_evt(ovf_evt),
    .cfg_q(cfg_q), .int_clr(int_clr), .bst_clr(bst_clr),
    .intr_q(intr_q), .bstat_q(bstat_q)
  );

  assign dreq = active;
  assign eot  = eot_q;
endmodule

// File: rtl/dxc_checker.sv
module dxc_checker
  import dxc_pkg::*;
#(
  parameter cnt_t ITL_MAX = 16'h0800,
  parameter cnt_t ATL_MAX = 16'h1000
)(
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [7:0]  acc_code,
  input logic [15:0] acc_wdata,
  input logic        dack,
  input logic        dreq,
  input logic        eot,
  input cfg_t        cfg_q,
  input cnt_t        len_q,
  input cnt_t        count_q,
  input logic [3:0]  intr_q,
  input logic        start_evt
);
  logic len_big;
  assign len_big = acc_valid && (acc_code == CMD_LEN_WR) &&
                   (acc_wdata > (cfg_q.buf_atl ? ATL_MAX : ITL_MAX));

  AST_CLAMP_STORES_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    len_big |=> (len_q == ($past(cfg_q.buf_atl) ? ATL_MAX : ITL_MAX)) && intr_q[INT_OVF]); // R3
  AST_NO_DREQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> (len_q != '0) && (count_q == '0)); // R4
  AST_COUNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && cfg_q.cnt_sel) |-> (count_q < len_q)); // R5
  AST_EOT_DROPS_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (!dreq && $past(dreq))); // R6
  AST_EOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot); // R6
  AST_EOT_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> intr_q[INT_ALLEOT]); // R9
  AST_IDLE_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dreq && !start_evt) |=> $stable(count_q)); // R11
endmodule

bind dma_xfer_counter dxc_checker #(.ITL_MAX(ITL_MAX), .ATL_MAX(ATL_MAX)) u_chk (.*);

// File: tb/sim_dma_xfer_counter.sv
`timescale 1ns/1ps
module sim_dma_xfer_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [7:0]  acc_code = 8'h00;
  logic [15:0] acc_wdata = 16'h0;
  logic [15:0] acc_rdata;
  logic        dack = 1'b0;
  logic        ext_eot = 1'b0;
  logic        dreq, eot;
  int nvec = 0;
  int nfail = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  dma_xfer_counter u0 (.*);

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] c, input logic [15:0] d);
    acc_valid = 1'b1; acc_code = c; acc_wdata = d;
    cyc();
    acc_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] c, output logic [15:0] d);
    acc_valid = 1'b1; acc_code = c;
    cyc();
    acc_valid = 1'b0;
    d = acc_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    wr(8'hA4, 16'hF); wr(8'hAC, 16'hF);
  endtask

  // full counter-mode transfer, checks R4 R5 R6 R9 R10
  task automatic run_xfer(input int len, input bit atl, input bit dirw);
    int n;
    int guard;
    clear_flags();
    wr(8'hA1, {13'b0, 1'b1, atl, dirw});          // configure, counter on
    wr(8'hA2, 16'(len));
    wr(8'hA1, {11'b0, 1'b1, 1'b0, 1'b1, atl, dirw}); // enable
    chk("R4 dreq after enable", dreq, 1);
    n = 0; guard = 0;
    while (dreq && guard < 5000) begin
      dack = 1'b1; cyc(); n++; guard++;
    end
    dack = 1'b0;
    chk("R6 eot with dreq fall", eot, 1);
    chk("R5 strobe count", n, (len + 1) / 2);
    cyc();
    chk("R6 eot one cycle", eot, 0);
    rd(8'h23, rv); chk("R5 final byte count", rv, len);
    rd(8'h24, rv); chk("R9 alleot set", rv[2], 1);
    rd(8'h2C, rv); chk("R10 buffer status", rv, 16'(1) << (dirw ? (atl ? 1 : 0) : (atl ? 3 : 2)));
    rd(8'h21, rv); chk("R2 config readback idle", rv, {13'b0, 1'b1, atl, dirw});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 dreq", dreq, 0); chk("R1 eot", eot, 0);
    rd(8'h22, rv); chk("R1 length", rv, 0);
    rd(8'h23, rv); chk("R1 count", rv, 0);
    rd(8'h21, rv); chk("R1 config", rv, 0);
    rd(8'h24, rv); chk("R1 intr", rv, 0);
    rd(8'h2C, rv); chk("R1 bstat", rv, 0);

    // R2 plain write/read
    wr(8'hA1, 16'h0003); wr(8'hA2, 16'h0123);
    rd(8'h22, rv); chk("R2 length readback", rv, 16'h0123);
    rd(8'h21, rv); chk("R2 config readback", rv, 16'h0003);

    // R3 clamp sweep around both limits
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 4; k++) begin
        int lim;
        int v;
        int expv;
        lim = b ? 16'h1000 : 16'h0800;
        v = (k == 3) ? 16'hFFFF : lim - 1 + k;
        expv = (v > lim) ? lim : v;
        clear_flags();
        wr(8'hA1, {14'b0, 1'(b), 1'b0});
        wr(8'hA2, 16'(v));
        rd(8'h22, rv); chk("R3 stored length", rv, expv);
        rd(8'h24, rv); chk("R3 overflow flag", rv[3], (v > lim) ? 1 : 0);
      end
    end

    // R5 R6 R10 sweep of short lengths, both buffers, both directions
    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 2; d++)
        for (int len = 1; len <= 12; len++)
          run_xfer(len, 1'(b), 1'(d));
    // boundary lengths
    run_xfer(16'h0800, 1'b0, 1'b1);
    run_xfer(16'h1000, 1'b1, 1'b0);

    // R11 dack while idle
    dack = 1'b1; cyc(); cyc(); cyc(); dack = 1'b0;
    rd(8'h23, rv); chk("R11 idle dack count", rv, 16'h1000);

    // R9 write-one-to-clear
    wr(8'hA4, 16'h0); rd(8'h24, rv); chk("R9 zero write keeps", rv[2], 1);
    wr(8'hA4, 16'h4); rd(8'h24, rv); chk("R9 one write clears", rv[2], 0);
    wr(8'hAC, 16'hF); rd(8'h2C, rv); chk("R10 status clear", rv, 0);

    // R4 zero length never starts
    wr(8'hA2, 16'h0); wr(8'hA1, 16'h0014);
    chk("R4 zero length dreq", dreq, 0);
    rd(8'h21, rv); chk("R4 zero length not running", rv[4], 0);

    // R8 ext_eot ignored while idle
    ext_eot = 1'b1; cyc(); ext_eot = 1'b0;
    chk("R8 idle ext_eot no eot", eot, 0);
    rd(8'h24, rv); chk("R8 idle ext_eot no int", rv[2], 0);

    // R7 counter not selected: passes length without ending
    clear_flags();
    wr(8'hA2, 16'd4); wr(8'hA1, 16'h0011);
    for (int i = 0; i < 5; i++) begin dack = 1'b1; cyc(); end
    dack = 1'b0;
    chk("R7 dreq still high", dreq, 1);
    chk("R7 no eot", eot, 0);
    rd(8'h23, rv); chk("R7 count past length", rv, 10);
    rd(8'h21, rv); chk("R2 running bit", rv[4], 1);
    ext_eot = 1'b1; cyc(); ext_eot = 1'b0;
    chk("R8 ext eot pulse", eot, 1); chk("R8 dreq dropped", dreq, 0);
    rd(8'h24, rv); chk("R9 alleot by ext", rv[2], 1);
    rd(8'h2C, rv); chk("R10 itl full", rv, 1);

    // R8 ext_eot mid-transfer in counter mode
    clear_flags();
    wr(8'hA2, 16'd20); wr(8'hA1, 16'h0016);
    for (int i = 0; i < 3; i++) begin dack = 1'b1; cyc(); end
    dack = 1'b0;
    ext_eot = 1'b1; cyc(); ext_eot = 1'b0;
    chk("R8 early end eot", eot, 1); chk("R8 early end dreq", dreq, 0);
    rd(8'h23, rv); chk("R8 count at early end", rv, 6);
    rd(8'h2C, rv); chk("R10 atl done", rv, 16'h8);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule